// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block turns any one of a wide bank of general-purpose input pins into an interrupt request on one of eight channels. Every channel has its own settings: the pin it watches, whether it reports a level or a single-cycle pulse on an edge, whether the pin's active state is high or low, and how many consecutive samples a new pin value must hold before it is believed.

The pin vector first passes through a two-flop synchronizer. Each channel then picks its pin, inverts it when low polarity is chosen, and applies the glitch filter. Finally it drives either the filtered level or a pulse on the filtered rising transition. The consumer therefore always sees active-high requests. Configuration lives in four 32-bit registers behind a single-cycle port. A write is taken on the clock edge and a read returns combinationally from the presented address.

Top module: `gpio_irq_router`

## Requirements
- R1: The four configuration registers reset to zero and read back exactly the 32 bits last written. Addresses are: 0 for the pin selectors of channels 0 to 3, 1 for the pin selectors of channels 4 to 7, 2 for mode and polarity, and 3 for filter lengths. The read data follows the address in the same cycle.
- R2: Channel k takes its 8-bit pin selector from bits 8*(k mod 4)+7 down to 8*(k mod 4) of register 0 when k < 4, and of register 1 otherwise.
- R3: In register 2, bit k set to 1 puts channel k in edge mode. Set to 0, it puts channel k in level mode, where the output follows the filtered signal.
- R4: In register 2, bit k+16 set to 1 inverts the pin for channel k, so a low pin (or a falling transition) raises that channel's active-high output.
- R5: With a filter length of 0 or 1, a pin change that is held reaches a level-mode output at the third rising clock edge after it is applied. Two of those edges are spent in the synchronizer.
- R6: Channel k's 4-bit filter length N sits at bits 4k+3 down to 4k of register 3. A new polarity-corrected value is accepted on the N-th consecutive clock in which it differs from the accepted value. A shorter excursion is discarded. N = 0 disables filtering, which behaves the same as N = 1.
- R7: In edge mode a channel drives a pulse exactly one clock long when its accepted value goes from 0 to 1.
- R8: A pin selector value at or above the number of implemented pins makes the channel's output stay 0, whatever its polarity.
- R9: All interrupt outputs are 0 while reset is held and directly after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous GPIO input bank |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register address for both read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| irq_o | output | 8 | Active-high interrupt request per channel |

## Verification
On every cycle, the assertions check that a written register holds its new value one clock later. They also check that a channel's accepted value changes only on an accept event, that the bypass setting copies the corrected pin after one clock, and that an edge-mode output never stays high for two cycles. The bench runs a cycle model of the requirements against every output in every cycle. That model is the only way to show end-to-end properties: the three-edge latency, the discarding of pulses shorter than the filter length, the routing of each selector field to its channel, the inversion for low polarity, and the silence of an out-of-range selector.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W      = 32;
  localparam int SEL_W      = 8;
  localparam int FILT_W     = 4;
  localparam int NUM_CH     = 8;
  localparam int NUM_REGS   = 4;
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int CH_PER_SEL = REG_W / SEL_W;
  localparam int POL_OFS    = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL_LO = 2'd0,
    A_SEL_HI = 2'd1,
    A_MODE   = 2'd2,
    A_FILT   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              edge_en;
    logic              pol_low;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_cfg(input logic [REG_W-1:0] sel_lo,
                                           input logic [REG_W-1:0] sel_hi,
                                           input logic [REG_W-1:0] mode,
                                           input logic [REG_W-1:0] filt,
                                           input int k);
    chan_cfg_t c;
    logic [REG_W-1:0] s;
    s         = (k < CH_PER_SEL) ? sel_lo : sel_hi;
    c.sel     = s[SEL_W*(k % CH_PER_SEL) +: SEL_W];
    c.edge_en = mode[k];
    c.pol_low = mode[k + POL_OFS];
    c.filt    = filt[FILT_W*k +: FILT_W];
    return c;
  endfunction

  function automatic logic filt_reached(input logic [FILT_W-1:0] cnt,
                                        input logic [FILT_W-1:0] lim);
    logic [FILT_W:0] nxt;
    nxt = {1'b0, cnt} + 1'b1;
    return (lim == '0) || (nxt >= {1'b0, lim});
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output chan_cfg_t [NUM_CH-1:0] cfg_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
    assign cfg_o[k] = decode_cfg(regs_q[A_SEL_LO], regs_q[A_SEL_HI],
                                 regs_q[A_MODE], regs_q[A_FILT], k);
  end

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> regs_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  chan_cfg_t           cfg_i,
  output logic                irq_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic              sel_valid;
  logic              raw_pin;
  logic              corr;
  logic              differs;
  logic              accept_ev;
  logic              rise_ev;
  logic              filt_q;
  logic              filt_d;
  logic [FILT_W-1:0] cnt_q;

  assign sel_valid = int'(cfg_i.sel) < NUM_PINS;
  assign raw_pin   = sel_valid ? pins_i[cfg_i.sel[IDX_W-1:0]] : 1'b0;
  assign corr      = sel_valid & (raw_pin ^ cfg_i.pol_low);
  assign differs   = corr != filt_q;
  assign accept_ev = differs && filt_reached(cnt_q, cfg_i.filt);
  assign rise_ev   = filt_q & ~filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      filt_d <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_d <= filt_q;
      if (accept_ev) begin
        filt_q <= corr;
        cnt_q  <= '0;
      end else if (!differs || cfg_i.filt == '0) begin
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign irq_o = cfg_i.edge_en ? rise_ev : filt_q;

  // R6
  hold_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_ev |=> $stable(filt_q));

  // R6
  bypass_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.filt == '0) |=> filt_q == $past(corr));

  // R7
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.edge_en && irq_o) |=> (!irq_o || !cfg_i.edge_en));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PINS-1:0]   pins_sync;
  chan_cfg_t [NUM_CH-1:0] cfg;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  gpio_irq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .cfg_o   (cfg)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    gpio_irq_chan #(.NUM_PINS(NUM_PINS)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (pins_sync),
      .cfg_i  (cfg[k]),
      .irq_o  (irq_o[k])
    );
  end

  // R9
  quiet_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> irq_o == '0);
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int NCH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int failures = 0;
  bit rand_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_dut (
    .clk (clk), .rst_n (rst_n), .pins_i (pins),
    .cfg_we (we), .cfg_addr (addr), .cfg_wdata (wdata),
    .cfg_rdata (rdata), .irq_o (irq)
  );

  // Reference model built from the requirements
  logic [31:0]   shadow [4];
  logic [NP-1:0] m_s1, m_s2;
  bit            m_acc  [NCH];
  bit            m_accp [NCH];
  bit            m_last [NCH];
  int            m_run  [NCH];

  function automatic int f_sel(int k);
    return (k < 4) ? int'((shadow[0] >> (8*k)) & 32'hFF)
                   : int'((shadow[1] >> (8*(k-4))) & 32'hFF);
  endfunction
  function automatic int f_len(int k);
    int n;
    n = int'((shadow[3] >> (4*k)) & 32'hF);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic bit f_edge(int k); return shadow[2][k]; endfunction
  function automatic bit f_pol(int k);  return shadow[2][k+16]; endfunction

  function automatic logic [NCH-1:0] expected_irq();
    logic [NCH-1:0] e;
    for (int k = 0; k < NCH; k++)
      e[k] = f_edge(k) ? (m_acc[k] && !m_accp[k]) : m_acc[k];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) shadow[i] = '0;
      m_s1 = '0; m_s2 = '0;
      for (int k = 0; k < NCH; k++) begin
        m_acc[k] = 0; m_accp[k] = 0; m_last[k] = 0; m_run[k] = 0;
      end
    end else begin
      for (int k = 0; k < NCH; k++) begin
        int s; bit c;
        s = f_sel(k);
        c = (s < NP) ? (m_s2[s] ^ f_pol(k)) : 1'b0;
        if (c == m_last[k]) m_run[k] = m_run[k] + 1;
        else m_run[k] = 1;
        m_last[k] = c;
        m_accp[k] = m_acc[k];
        if (c != m_acc[k] && m_run[k] >= f_len(k)) m_acc[k] = c;
      end
      m_s2 = m_s1;
      m_s1 = pins;
      if (we) shadow[addr] = wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(irq == expected_irq(), "R3 R6 model", 32'(irq), 32'(expected_irq()));
    if (rand_on) begin
      for (int i = 0; i < NP; i++)
        if (($urandom % 16) == 0) pins[i] = ~pins[i];
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk(rdata == 32'h0, "R1 reset value", rdata, 32'h0);
    end
    chk(irq == '0, "R9 reset outputs", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step();
    chk(irq == '0, "R9 after release", 32'(irq), 32'h0);

    // R5: three-edge latency, level mode, no filtering
    wr(2'd0, 32'h0000_0005);
    pins[5] = 1'b1;
    step(); chk(irq[0] == 1'b0, "R5 edge1", 32'(irq[0]), 0);
    step(); chk(irq[0] == 1'b0, "R5 edge2", 32'(irq[0]), 0);
    step(); chk(irq[0] == 1'b1, "R5 edge3", 32'(irq[0]), 1);

    // R4: low polarity inverts
    wr(2'd2, 32'h0001_0000);
    step(); chk(irq[0] == 1'b0, "R4 high pin masked", 32'(irq[0]), 0);
    pins[5] = 1'b0;
    steps(3); chk(irq[0] == 1'b1, "R4 low pin raises", 32'(irq[0]), 1);

    // R7: edge mode pulse of one cycle
    wr(2'd2, 32'h0000_0001);
    steps(4);
    pins[5] = 1'b1;
    steps(3); chk(irq[0] == 1'b1, "R7 pulse high", 32'(irq[0]), 1);
    step();   chk(irq[0] == 1'b0, "R7 pulse ends", 32'(irq[0]), 0);
    steps(3); chk(irq[0] == 1'b0, "R7 no repeat", 32'(irq[0]), 0);

    // R2: channel 5 selector field in register 1 bits 15:8
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0000_0A00);
    pins[10] = 1'b1;
    steps(3);
    chk(irq[5] == 1'b1, "R2 channel5 routes pin10", 32'(irq[5]), 1);
    chk(irq[4] == 1'b0, "R2 channel4 stays on pin0", 32'(irq[4]), 0);

    // R6: filter length 4 rejects a 3-cycle pulse, accepts a held value
    pins[5] = 1'b0;
    wr(2'd3, 32'h0000_0004);
    steps(8);
    chk(irq[0] == 1'b0, "R6 settled low", 32'(irq[0]), 0);
    pins[5] = 1'b1;
    steps(3);
    pins[5] = 1'b0;
    steps(10);
    chk(irq[0] == 1'b0, "R6 short pulse rejected", 32'(irq[0]), 0);
    pins[5] = 1'b1;
    steps(5); chk(irq[0] == 1'b0, "R6 not yet accepted", 32'(irq[0]), 0);
    step();   chk(irq[0] == 1'b1, "R6 accepted on fourth", 32'(irq[0]), 1);

    // R8: out-of-range selector stays quiet even with low polarity
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h0000_00C8);
    wr(2'd2, 32'h0001_0000);
    steps(8);
    chk(irq[0] == 1'b0, "R8 invalid selector quiet", 32'(irq[0]), 0);

    // R1: read back arbitrary patterns
    for (int a = 0; a < 4; a++) begin
      logic [31:0] v;
      v = $urandom;
      wr(2'(a), v);
      addr = 2'(a); #1;
      chk(rdata == v, "R1 readback", rdata, v);
    end

    // Random configurations and pin activity
    rand_on = 1'b1;
    for (int r = 0; r < 40; r++) begin
      logic [31:0] sl, sh, md, fl;
      for (int b = 0; b < 4; b++) begin
        int s;
        s = (($urandom % 10) == 0) ? (NP + int'($urandom % (256 - NP))) : int'($urandom % NP);
        sl[8*b +: 8] = 8'(s);
        s = (($urandom % 10) == 0) ? (NP + int'($urandom % (256 - NP))) : int'($urandom % NP);
        sh[8*b +: 8] = 8'(s);
      end
      md = $urandom;
      fl = '0;
      for (int k = 0; k < NCH; k++) fl[4*k +: 4] = 4'($urandom % 8);
      wr(2'd0, sl); wr(2'd1, sh); wr(2'd2, md); wr(2'd3, fl);
      addr = 2'd2; #1;
      chk(rdata == md, "R1 readback mode", rdata, md);
      steps(300);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule